// File: doc/BRIEF.md
# Dual-Select Asynchronous SRAM Device Model

This block is a synthesizable, clock-sampled stand-in for a 131,072 x 8 asynchronous static RAM. It is meant for on-chip simulation and FPGA emulation, where a real tri-state memory device cannot be used. Two chip selects of opposite polarity gate every access: one is active-low and one is active-high. An active-low write strobe and an active-low output gate then choose between write, read and an idle state in which the device is powered but its outputs are off. A write overrides the output gate.

The bidirectional data bus is split into three signals: a write-data input, a read-data output and a drive flag that stands for the tri-state driver. A power flag reports whether the device is active or in standby. On every rising clock edge the model samples the address and controls. A write stores the byte at that same edge. The outputs then show the mode that was sampled, and in read mode they show the byte held at the sampled address. The storage depth can be reduced for simulation. When it is, the upper address bits are ignored and the address space aliases onto the smaller array.

Top module: `sram_device_model`

## Requirements
- R1: While `sel_lo_n` is 1 at a rising edge, the following cycle shows `rd_drive`=0 and `pwr_active`=0, whatever the other controls are, and no byte is stored.
- R2: While `sel_hi` is 0 at a rising edge, the following cycle shows `rd_drive`=0 and `pwr_active`=0, whatever the other controls are, and no byte is stored.
- R3: With `sel_lo_n`=0, `sel_hi`=1, `wr_strobe_n`=1 and `out_gate_n`=1 sampled, the device is powered (`pwr_active`=1) and does not drive (`rd_drive`=0).
- R4: With both selects asserted, `wr_strobe_n`=1 and `out_gate_n`=0 sampled, `rd_drive`=1 and `rd_data` equals the byte last stored at the sampled address.
- R5: With both selects asserted and `wr_strobe_n`=0 sampled, `wr_data` is stored at the sampled address at that edge. `out_gate_n` has no effect: `rd_drive`=0 and `pwr_active`=1.
- R6: A read sampled one edge after a write to the same address returns the new byte.
- R7: Whenever `rd_drive` is 0, `rd_data` is all zeros.
- R8: While `rst_n` is 0, outputs show standby and no byte is stored, even if a write is presented.
- R9: Only the low `ARRAY_AW` address bits select a location (default 10), so addresses that differ only above that bit alias to the same byte.
- R10: Outputs change only at rising edges. They reflect the controls sampled at the most recent edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sampled state |
| addr | input | ADDR_W (17) | Byte address |
| sel_lo_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| wr_strobe_n | input | 1 | Active-low write strobe |
| out_gate_n | input | 1 | Active-low output gate |
| wr_data | input | DATA_W (8) | Byte to store |
| rd_data | output | DATA_W (8) | Byte read, zero when not driving |
| rd_drive | output | 1 | Stands for the tri-state driver being on |
| pwr_active | output | 1 | 1 when the device is active, 0 in standby |

## Verification
The hardest situations to reach are the ones where a write is presented but must not land: a write issued while one of the two selects is deasserted, and a write issued during reset. The bench first stores a known byte at a location. It then replays the write strobe with different data under each blocking condition, and finally selects the device and reads the location back to show that the old byte survived. Aliasing is exercised by writing through an address with high bits set and reading through the bare low address. A long pseudo-random run over a small pool of pre-written addresses then mixes every mode, compared against a behavioural model on each clock.

// File: rtl/sram_dev_pkg.sv
package sram_dev_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_IDLE    = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } sram_mode_e;

    typedef struct packed {
        logic lo_ok;
        logic hi_ok;
    } sel_pair_t;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_dev_pkg::*;
(
    input  logic       sel_lo_n,
    input  logic       sel_hi,
    input  logic       wr_strobe_n,
    input  logic       out_gate_n,
    output sram_mode_e mode
);

    sel_pair_t sel_w;
    logic      picked_w;

    always_comb begin
        sel_w.lo_ok = ~sel_lo_n;
        sel_w.hi_ok = sel_hi;
        picked_w    = sel_w.lo_ok & sel_w.hi_ok;
    end

    // Selection gates everything; a write strobe overrides the output gate.
    always_comb begin
        if (!picked_w) begin
            mode = MODE_STANDBY;
        end else if (!wr_strobe_n) begin
            mode = MODE_WRITE;
        end else if (!out_gate_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_IDLE;
        end
    end

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
    parameter int LOC_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [LOC_W-1:0]  wr_loc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LOC_W-1:0]  rd_loc,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << LOC_W;

    typedef struct packed {
        logic              en;
        logic [LOC_W-1:0]  loc;
        logic [DATA_W-1:0] val;
    } wreq_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    wreq_t             wreq_d;

    always_comb begin
        wreq_d.en  = wr_go & rst_n;
        wreq_d.loc = wr_loc;
        wreq_d.val = wr_data;
    end

    // Content is left undefined at power-up, as on the device.
    always_ff @(posedge clk) begin
        if (wreq_d.en) begin
            mem_q[wreq_d.loc] <= wreq_d.val;
        end
    end

    assign rd_data = mem_q[rd_loc];

    // R5: a granted write is held by the array after the edge
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (mem_q[$past(wr_loc)] == $past(wr_data)));

endmodule

// File: rtl/sram_device_model.sv
module sram_device_model
    import sram_dev_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int ARRAY_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              wr_strobe_n,
    input  logic              out_gate_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    output logic              pwr_active
);

    localparam int LOC_W = (ARRAY_AW < ADDR_W) ? ARRAY_AW : ADDR_W;

    typedef struct packed {
        sram_mode_e       mode;
        logic [LOC_W-1:0] loc;
    } smp_t;

    sram_mode_e        mode_now;
    logic [LOC_W-1:0]  loc_now;
    logic              wr_go;
    logic [DATA_W-1:0] arr_word;
    smp_t              smp_d;
    smp_t              smp_q;

    sram_mode_decode u_dec (
        .sel_lo_n    (sel_lo_n),
        .sel_hi      (sel_hi),
        .wr_strobe_n (wr_strobe_n),
        .out_gate_n  (out_gate_n),
        .mode        (mode_now)
    );

    // Full-depth array uses the address as is; a reduced one aliases.
    generate
        if (LOC_W == ADDR_W) begin : g_full
            assign loc_now = addr;
        end else begin : g_alias
            assign loc_now = addr[LOC_W-1:0];
        end
    endgenerate

    always_comb begin
        smp_d.mode = mode_now;
        smp_d.loc  = loc_now;
        wr_go      = rst_n && (mode_now == MODE_WRITE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '{mode: MODE_STANDBY, loc: '0};
        end else begin
            smp_q <= smp_d;
        end
    end

    sram_byte_array #(
        .LOC_W  (LOC_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_loc  (loc_now),
        .wr_data (wr_data),
        .rd_loc  (smp_q.loc),
        .rd_data (arr_word)
    );

    always_comb begin
        rd_drive   = (smp_q.mode == MODE_READ);
        pwr_active = (smp_q.mode != MODE_STANDBY);
        rd_data    = rd_drive ? arr_word : '0;
    end

    // R1: active-low select high forces standby next cycle
    p_lo_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lo_n |=> (!pwr_active && !rd_drive));

    // R2: active-high select low forces standby next cycle
    p_hi_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_hi |=> (!pwr_active && !rd_drive));

    // R5: write ignores the output gate, device stays powered
    p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && !wr_strobe_n) |=> (pwr_active && !rd_drive));

    // R3: idle selection keeps power on without driving
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && wr_strobe_n && out_gate_n) |=> (pwr_active && !rd_drive));

    // R7: a quiet bus carries zeros
    p_quiet_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

endmodule

// File: tb/sram_device_model_tb.sv
`timescale 1ns/100ps
module sram_device_model_tb_top;

    localparam int AW  = 17;
    localparam int DW  = 8;
    localparam int AAW = 10;
    localparam int MASK = (1 << AAW) - 1;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sel_lo_n = 1'b1;
    logic          sel_hi = 1'b0;
    logic          wr_strobe_n = 1'b1;
    logic          out_gate_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;
    logic          pwr_active;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    logic [7:0] ref_mem [int];

    always #2.5 clk = ~clk;

    sram_device_model #(.ADDR_W(AW), .DATA_W(DW), .ARRAY_AW(AAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .wr_strobe_n(wr_strobe_n), .out_gate_n(out_gate_n), .wr_data(wr_data),
        .rd_data(rd_data), .rd_drive(rd_drive), .pwr_active(pwr_active)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, let the rising edge sample,
    // update the behavioural model, then compare at the next falling edge.
    task automatic cyc(input logic lo_n, input logic hi, input logic wrn, input logic oen,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        bit sel_ok, e_rd, e_act, known;
        int key;
        logic [7:0] e_dat;
        sel_lo_n = lo_n; sel_hi = hi; wr_strobe_n = wrn; out_gate_n = oen;
        addr = a; wr_data = d;
        @(posedge clk);
        key    = int'(a) & MASK;
        sel_ok = rst_n && !lo_n && hi;
        e_act  = sel_ok;
        e_rd   = sel_ok && wrn && !oen;
        if (sel_ok && !wrn) ref_mem[key] = d;
        known  = ref_mem.exists(key);
        e_dat  = (e_rd && known) ? ref_mem[key] : 8'h00;
        @(negedge clk);
        check(tag, "pwr_active", int'(pwr_active), int'(e_act));
        check(tag, "rd_drive", int'(rd_drive), int'(e_rd));
        if (!e_rd || known) check(tag, "rd_data", int'(rd_data), int'(e_dat));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before the test ended");
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        // R8: reset with a write presented shows standby
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 17'd5, 8'h99, "R8");
        rst_n = 1'b1;
        cyc(1, 0, 1, 1, 17'd0, 8'h00, "R1");
        // R5: writes with the output gate low still do not drive
        cyc(0, 1, 0, 0, 17'd5, 8'h11, "R5");
        cyc(0, 1, 0, 1, 17'd6, 8'h22, "R5");
        // R8: a write during reset must not land
        rst_n = 1'b0;
        cyc(0, 1, 0, 1, 17'd5, 8'h99, "R8");
        rst_n = 1'b1;
        cyc(0, 1, 1, 0, 17'd5, 8'h00, "R8");
        // R1 and R2: deselected writes do not land
        cyc(1, 1, 0, 0, 17'd6, 8'h77, "R1");
        cyc(0, 1, 1, 0, 17'd6, 8'h00, "R1");
        cyc(0, 0, 0, 0, 17'd6, 8'h66, "R2");
        cyc(1, 0, 0, 1, 17'd6, 8'h55, "R2");
        cyc(0, 1, 1, 0, 17'd6, 8'h00, "R2");
        // R3: idle with power on
        cyc(0, 1, 1, 1, 17'd6, 8'h00, "R3");
        // R6: read right after write to the same address
        cyc(0, 1, 0, 1, 17'd9, 8'h3c, "R6");
        cyc(0, 1, 1, 0, 17'd9, 8'h00, "R6");
        cyc(0, 1, 0, 0, 17'd9, 8'hc3, "R6");
        cyc(0, 1, 1, 0, 17'd9, 8'h00, "R6");
        // R9: aliasing above the array width
        cyc(0, 1, 0, 1, 17'd3 + (17'd5 << AAW), 8'h5a, "R9");
        cyc(0, 1, 1, 0, 17'd3, 8'h00, "R9");
        cyc(0, 1, 1, 0, 17'd3 + (17'd1 << (AW - 1)), 8'h00, "R9");
        // R4: fill a pool, then read it back
        for (int i = 0; i < 32; i++) cyc(0, 1, 0, 1, 17'(i), 8'(i * 37 + 1), "R4");
        for (int i = 31; i >= 0; i--) cyc(0, 1, 1, 0, 17'(i), 8'h00, "R4");
        // R10 and R7: pseudo-random mix of modes over the pool
        lfsr = 16'hace1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] & lfsr[1], lfsr[2] | lfsr[3], lfsr[4], lfsr[5],
                {lfsr[15:12], 8'h00, lfsr[10:6]} & 17'h1f01f, lfsr[15:8] ^ lfsr[7:0], "R10");
        end
        summary();
    end

endmodule